// File: doc/BRIEF.md
# Line Alarm Latch and Interrupt Controller

This block gathers alarm indications from a line receiver into three alarm registers of `W` bits each: a main register and two complementary ones. Every alarm bit has a mask bit. Any alarm bit that is set and unmasked pulls an active-low interrupt. A microprocessor reads the registers through a simple read port. A read returns the current contents and acknowledges them at the next clock edge.

Each alarm bit is one of two kinds, fixed by a parameter. An event bit takes a one-cycle pulse and holds it until software reads it. A state bit follows a level condition. Once it has been read, it stays set for as long as the condition lasts and drops as soon as the condition ends. One bit of the second complementary register is kept out of the interrupt entirely. The registers can also be polled, with no use of the interrupt.

In stand-alone mode the interrupt output is held high. The block instead presents a status byte for the frame's first time slot, built from the current line conditions.

Top module: `alarm_irq_ctrl`

## Requirements
- R1: After reset every alarm bit reads 0, every mask bit is 1 (masked) and `irq_n_o` is 1.
- R2: An alarm bit contributes to the interrupt only when its mask bit is 0. A mask bit of 1 removes its contribution.
- R3: Outside stand-alone mode, `irq_n_o` is 0 exactly while at least one unmasked, interrupt-capable alarm bit is set, and 1 otherwise.
- R4: `rd_en_i` with `addr_i` 0, 1 or 2 selects the main, first or second complementary alarm register. `rdata_o` shows it in the same cycle, and `addr_i` 3 reads 0. Event bits are the bits set in `EVT0`/`EVT1`/`EVT2` (defaults 8'hF0, 8'h55, 8'h0F). An event bit is set by a cause pulse and returns to 0 at the clock edge that ends a read of its register.
- R5: If a cause arrives in the same cycle as a read of its register, the bit is 1 after that edge.
- R6: A state bit that is read while its cause is still present stays 1 for as long as the cause stays present.
- R7: A state bit that has been read clears at the first edge at which its cause is absent. A state bit whose cause ends without a read stays 1 until its register is read.
- R8: Bit `NOIRQ_BIT` (default 7) of the second complementary register never affects `irq_n_o`, whatever its mask.
- R9: While `sa_i` is 1, `irq_n_o` is 1.
- R10: While `sa_i` is 1, `ts0_o` from bit 7 down to bit 0 is: fast/slow, loss of signal, AIS, B, loss of frame, multiframe not recovered, A bit received, skip. `line_flags_i` carries these flags without B, as bit 6 fast/slow, 5 loss of signal, 4 AIS, 3 loss of frame, 2 multiframe not recovered, 1 A bit, 0 skip.
- R11: Bit 4 (B) of `ts0_o` equals `b_frm_i` when loss of frame is 1 and `b_wer_i` when it is 0.
- R12: While `sa_i` is 0, `ts0_o` is all ones.
- R13: `wr_en_i` with `addr_i` 0, 1 or 2 loads `wdata_i` into that register's mask at the clock edge. A write with `addr_i` 3 changes no mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cause0_i | input | W | Alarm causes for the main register |
| cause1_i | input | W | Alarm causes for the first complementary register |
| cause2_i | input | W | Alarm causes for the second complementary register |
| rd_en_i | input | 1 | Read strobe, acknowledges the selected register |
| wr_en_i | input | 1 | Mask write strobe |
| addr_i | input | 2 | Register select for reads and mask writes |
| wdata_i | input | W | Mask write data |
| rdata_o | output | W | Contents of the selected alarm register |
| irq_n_o | output | 1 | Active-low interrupt |
| sa_i | input | 1 | Stand-alone mode |
| line_flags_i | input | 7 | Current line conditions for the status byte |
| b_frm_i | input | 1 | B source used while loss of frame is set |
| b_wer_i | input | 1 | Word-error B source used while loss of frame is clear |
| ts0_o | output | 8 | Stand-alone status byte |

## Verification
The bench uses the default parameters: 8-bit registers, event maps 8'hF0, 8'h55 and 8'h0F, and bit 7 of the second complementary register as the excluded bit. With these values every register holds both kinds of bit, and contiguous as well as interleaved event masks are exercised. The excluded bit is a state bit, so it can be held set for many cycles while its neighbours toggle the interrupt. Random pulse and level causes, mixed with reads, mask writes and mode switches, bring read/cause collisions and acknowledged state bits whose cause later ends within reach of every register.

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl #(
  parameter int W = 8,
  parameter logic [W-1:0] EVT0 = 8'hF0,
  parameter logic [W-1:0] EVT1 = 8'h55,
  parameter logic [W-1:0] EVT2 = 8'h0F,
  parameter int NOIRQ_BIT = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cause0_i,
  input  logic [W-1:0] cause1_i,
  input  logic [W-1:0] cause2_i,
  input  logic         rd_en_i,
  input  logic         wr_en_i,
  input  logic [1:0]   addr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  output logic         irq_n_o,
  input  logic         sa_i,
  input  logic [6:0]   line_flags_i,
  input  logic         b_frm_i,
  input  logic         b_wer_i,
  output logic [7:0]   ts0_o
);
  localparam int N = 3;
  localparam int NB = N * W;
  localparam logic [NB-1:0] EVT = {EVT2, EVT1, EVT0};
  localparam logic [NB-1:0] ONE = NB'(1);
  localparam logic [NB-1:0] IRQ_OK = ~(ONE << (2 * W + NOIRQ_BIT));

  logic [NB-1:0] alm, ack, msk, cause, clr, wsel;

  assign cause = {cause2_i, cause1_i, cause0_i};

  for (genvar r = 0; r < N; r++) begin : g_sel
    assign clr[r*W +: W]  = {W{rd_en_i && addr_i == 2'(r)}};
    assign wsel[r*W +: W] = {W{wr_en_i && addr_i == 2'(r)}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alm <= '0;
      ack <= '0;
      msk <= '1;
    end else begin
      alm <= cause | (alm & ~clr & ~ack);
      ack <= cause & ~EVT & (ack | clr);
      msk <= (msk & ~wsel) | ({N{wdata_i}} & wsel);
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int r = 0; r < N; r++)
      if (addr_i == 2'(r)) rdata_o = alm[r*W +: W];
  end

  assign irq_n_o = sa_i | ~|(alm & ~msk & IRQ_OK);

  logic b_bit;
  assign b_bit = line_flags_i[3] ? b_frm_i : b_wer_i;
  assign ts0_o = sa_i ? {line_flags_i[6:4], b_bit, line_flags_i[3:0]} : 8'hFF;
endmodule

// File: rtl/alarm_irq_ctrl_chk.sv
module alarm_irq_ctrl_chk #(
  parameter int W = 8,
  parameter logic [3*W-1:0] EVT = '0,
  parameter int NOIRQ_BIT = 7
) (
  input logic           clk,
  input logic           rst_n,
  input logic           sa_i,
  input logic           irq_n_o,
  input logic [7:0]     ts0_o,
  input logic           rd_en_i,
  input logic [1:0]     addr_i,
  input logic [3*W-1:0] cause,
  input logic [3*W-1:0] alm,
  input logic [3*W-1:0] msk,
  input logic           lof_i,
  input logic           b_frm_i
);
  logic [3*W-1:0] allow;
  always_comb begin
    allow = '1;
    allow[2*W + NOIRQ_BIT] = 1'b0;
  end

  p_sa_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sa_i |-> irq_n_o);

  p_idle_byte_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !sa_i |-> ts0_o == 8'hFF);

  p_cause_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i |=> ((alm & $past(cause)) == $past(cause)));

  p_evt_rdclr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && addr_i == 2'd0 && (cause[W-1:0] & EVT[W-1:0]) == '0)
    |=> (alm[W-1:0] & EVT[W-1:0]) == '0);

  p_quiet_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((alm & ~msk & allow) == '0) |-> irq_n_o);

  p_b_lof_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sa_i && lof_i) |-> ts0_o[4] == b_frm_i);
endmodule

bind alarm_irq_ctrl alarm_irq_ctrl_chk #(
  .W(W), .EVT({EVT2, EVT1, EVT0}), .NOIRQ_BIT(NOIRQ_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sa_i(sa_i), .irq_n_o(irq_n_o), .ts0_o(ts0_o),
  .rd_en_i(rd_en_i), .addr_i(addr_i), .cause({cause2_i, cause1_i, cause0_i}),
  .alm(alm), .msk(msk), .lof_i(line_flags_i[3]), .b_frm_i(b_frm_i)
);

// File: tb/sim_alarm_irq_ctrl.sv
`timescale 1ns/100ps
module sim_alarm_irq_ctrl;
  localparam int W = 8;
  localparam logic [23:0] EVTM = {8'h0F, 8'h55, 8'hF0};
  localparam int XBIT = 16 + 7;

  logic clk = 0, rst_n = 0;
  logic [W-1:0] cause0 = 0, cause1 = 0, cause2 = 0, wdata = 0;
  logic rd_en = 0, wr_en = 0, sa = 0, b_frm = 0, b_wer = 0;
  logic [1:0] addr = 0;
  logic [6:0] flags = 0;
  logic [W-1:0] rdata;
  logic irq_n;
  logic [7:0] ts0;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [23:0] mv, ma, mm;

  always #2 clk = ~clk;

  alarm_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cause0_i(cause0), .cause1_i(cause1), .cause2_i(cause2),
    .rd_en_i(rd_en), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_n_o(irq_n), .sa_i(sa), .line_flags_i(flags),
    .b_frm_i(b_frm), .b_wer_i(b_wer), .ts0_o(ts0)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_rd();
    if (addr == 2'd3) return 8'h00;
    return mv[addr*8 +: 8];
  endfunction

  function automatic logic exp_irq();
    logic any = 0;
    if (sa) return 1'b1;
    for (int i = 0; i < 24; i++)
      if (i != XBIT && mv[i] && !mm[i]) any = 1;
    return !any;
  endfunction

  function automatic logic [7:0] exp_ts0();
    logic b;
    if (!sa) return 8'hFF;
    b = flags[3] ? b_frm : b_wer;
    return {flags[6], flags[5], flags[4], b, flags[3], flags[2], flags[1], flags[0]};
  endfunction

  task automatic settle();
    #1;
    chk("R4 R6 R7 rdata", 32'(rdata), 32'(exp_rd()));
    chk("R2 R3 R8 R9 irq_n", 32'(irq_n), 32'(exp_irq()));
    chk("R10 R11 R12 ts0", 32'(ts0), 32'(exp_ts0()));
  endtask

  task automatic adv();
    logic [23:0] c;
    c = {cause2, cause1, cause0};
    for (int i = 0; i < 24; i++) begin
      logic rd_hit;
      rd_hit = rd_en && addr == 2'(i / 8);
      if (wr_en && addr == 2'(i / 8)) mm[i] = wdata[i % 8];
      if (EVTM[i]) begin
        if (c[i]) mv[i] = 1;
        else if (rd_hit) mv[i] = 0;
      end else begin
        if (c[i]) begin
          ma[i] = ma[i] | rd_hit;
          mv[i] = 1;
        end else begin
          if (rd_hit || ma[i]) mv[i] = 0;
          ma[i] = 0;
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    rd_en = 0; wr_en = 0; cause0 = 0; cause1 = 0; cause2 = 0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog R1: actual=timeout expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [23:0] lvl;
    void'($urandom(32'd1234));
    mv = 0; ma = 0; mm = '1; lvl = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 3; a++) begin
      addr = 2'(a); #1;
      chk("R1 reset alarm", 32'(rdata), 0);
      @(negedge clk);
    end
    chk("R1 reset irq_n", 32'(irq_n), 1);
    cause0 = 8'hFF; cause1 = 8'hFF; cause2 = 8'hFF;
    settle(); adv();
    idle(); settle();
    chk("R1 masks set after reset", 32'(irq_n), 1);

    // R13, R2, R3: unmask main register
    wr_en = 1; addr = 0; wdata = 8'h00; settle(); adv();
    idle(); settle();
    chk("R2 R3 unmasked alarm drives irq", 32'(irq_n), 0);
    wr_en = 1; addr = 3; wdata = 8'hFF; settle(); adv();
    idle(); settle();
    chk("R13 write to addr 3 ignored", 32'(irq_n), 0);

    // R4: read clears
    rd_en = 1; addr = 0; settle();
    chk("R4 read shows alarms", 32'(rdata), 32'hFF);
    adv(); settle();
    chk("R4 R7 cleared after read", 32'(rdata), 0);
    idle(); addr = 1; rd_en = 1; settle(); adv();
    addr = 2; settle(); adv(); idle(); settle();
    chk("R3 irq released", 32'(irq_n), 1);

    // R5: event coincident with read
    cause0 = 8'h10; rd_en = 1; addr = 0; settle(); adv();
    idle(); settle();
    chk("R5 event wins over read", 32'(rdata), 32'h10);
    rd_en = 1; settle(); adv(); idle(); settle();

    // R6, R7: state bit
    cause0 = 8'h01; settle(); adv();
    rd_en = 1; settle();
    chk("R6 state bit set", 32'(rdata), 1);
    adv(); rd_en = 0; settle();
    chk("R6 held while cause present", 32'(rdata), 1);
    adv(); settle();
    chk("R6 still held", 32'(rdata), 1);
    cause0 = 0; settle(); adv(); settle();
    chk("R7 clears when cause ends", 32'(rdata), 0);
    cause0 = 8'h02; settle(); adv(); cause0 = 0; settle(); adv(); settle();
    chk("R7 unread state bit stays", 32'(rdata), 32'h02);
    rd_en = 1; settle(); adv(); idle(); settle();

    // R8: excluded bit
    wr_en = 1; addr = 2; wdata = 8'h00; settle(); adv();
    addr = 0; wdata = 8'hFF; settle(); adv();
    idle(); cause2 = 8'h80; settle(); adv(); settle();
    chk("R8 excluded bit no irq", 32'(irq_n), 1);
    cause2 = 8'h81; settle(); adv(); settle();
    chk("R2 neighbour bit irq", 32'(irq_n), 0);

    // R9, R10, R11, R12
    sa = 1; #1;
    chk("R9 stand-alone irq high", 32'(irq_n), 1);
    flags = 7'b1010101; b_frm = 1; b_wer = 0; #0.5;
    chk("R10 R11 byte, lof=0", 32'(ts0), 32'hA5);
    flags = 7'b0001000; #0.5;
    chk("R11 B from frame source", 32'(ts0), 32'h18);
    @(negedge clk);
    sa = 0; #1;
    chk("R12 idle byte", 32'(ts0), 32'hFF);
    @(negedge clk);
    idle(); addr = 2; rd_en = 1; settle(); adv(); idle(); settle();

    // random phase
    for (int k = 0; k < 4000; k++) begin
      logic [23:0] pulse;
      lvl ^= 24'($urandom) & 24'($urandom) & 24'($urandom);
      pulse = 24'($urandom) & 24'($urandom) & 24'($urandom);
      {cause2, cause1, cause0} = (pulse & EVTM) | (lvl & ~EVTM);
      rd_en = ($urandom % 3) == 0;
      wr_en = ($urandom % 6) == 0;
      addr = 2'($urandom);
      wdata = 8'($urandom);
      if ((k % 50) == 0) sa = ($urandom % 4) == 0;
      flags = 7'($urandom);
      b_frm = 1'($urandom);
      b_wer = 1'($urandom);
      settle(); adv();
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule